// File: doc/BRIEF.md
# Multi-Cycle Restoring Integer Divider

This block divides one WIDTH-bit integer by another over several clock cycles and returns a WIDTH-bit quotient and a WIDTH-bit remainder. The datapath is small. It has a divisor register, one subtractor that is one bit wider than the operands, and a single double-width working register. The partial remainder sits in the upper half of the working register, and the quotient bits shift in at the bottom of the lower half as the dividend bits leave it. The working register is shifted once before the first trial subtraction. That leaves the upper half one position too far left at the end, so a last step moves only the upper half back right by one bit.

A caller presents both operands and a mode select, then pulses `start` while the block is idle. The block stays busy for WIDTH+1 cycles and then pulses `done` for one cycle with the results. In signed mode the operands are converted to magnitudes before the iteration. The signs are applied afterwards, so the quotient truncates toward zero and the remainder takes the sign of the dividend. A zero divisor has a fixed result and takes the normal time.

Top module: `restoring_divider`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `done` are 0 and `quotient` and `remainder` are all zeros until the first division completes.
- R2: A `start` sampled high while `busy` is 0 is accepted: `busy` is 1 from the next cycle for exactly WIDTH+1 cycles.
- R3: `done` goes high for exactly one cycle, in the first cycle in which `busy` has returned to 0, and the new `quotient` and `remainder` appear in that same cycle.
- R4: With `is_signed`=0, operands are unsigned: quotient = floor(dividend/divisor) and remainder = dividend mod divisor, over the full range including operands with the top bit set.
- R5: With `is_signed`=1, operands are two's complement and the quotient is truncated toward zero; it is negative when the operand signs differ (for example 100/−7 gives −14).
- R6: In signed mode the remainder has the sign of the dividend or is zero: 7/4 gives 1 rem 3, −7/4 gives −1 rem −3, and 7/−4 gives −1 rem 3.
- R7: A zero divisor keeps the same WIDTH+1 cycle latency and yields a quotient of all ones and a remainder equal to the dividend, in either mode.
- R8: A `start` raised while `busy` is 1 is ignored. The running division finishes with the operands and mode that were captured when it was accepted.
- R9: `quotient` and `remainder` hold their values in every cycle except the one in which `done` is high.
- R10: In signed mode, the most negative value divided by −1 gives a quotient equal to that most negative value and a remainder of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division; taken only while idle |
| is_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | WIDTH | Dividend, captured on an accepted start |
| divisor | input | WIDTH | Divisor, captured on an accepted start |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | One-cycle pulse when the results are updated |
| quotient | output | WIDTH | Quotient of the latest completed division |
| remainder | output | WIDTH | Remainder of the latest completed division |

## Verification
A wrong internal state shows up at the ports only at the next `done`, because the working register is not visible until then. One wrong quotient bit or one bad restore therefore surfaces WIDTH+1 cycles after `start` as a wrong quotient or remainder. A missing extension bit shows up only for dividends with the top bit set, and a missing final shift shows up as a doubled remainder, so the bench uses operands that reach those cases. Mistakes in the counter or the control sequence show up at once, in the first cycle where `busy` or `done` differs from the cycle-by-cycle model.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ITER = 2'd1,
      PH_FIX  = 2'd2
   } rdiv_phase_t;
endpackage

// File: rtl/rdiv_operand_prep.sv
module rdiv_operand_prep #(
   parameter int WIDTH      = 32,
   parameter bit SIGNED_EN  = 1'b1
) (
   input  logic             is_signed,
   input  logic [WIDTH-1:0] dividend,
   input  logic [WIDTH-1:0] divisor,
   output logic [WIDTH-1:0] dvd_mag,
   output logic [WIDTH-1:0] dvs_mag,
   output logic             flip_quo,
   output logic             flip_rem,
   output logic             dvs_zero
);
   assign dvs_zero = (divisor == '0);

   generate
      if (SIGNED_EN) begin : g_signed
         logic dvd_neg, dvs_neg;
         assign dvd_neg  = is_signed & dividend[WIDTH-1];
         assign dvs_neg  = is_signed & divisor[WIDTH-1];
         assign dvd_mag  = dvd_neg ? (~dividend + 1'b1) : dividend;
         assign dvs_mag  = dvs_neg ? (~divisor + 1'b1) : divisor;
         assign flip_quo = dvd_neg ^ dvs_neg;
         assign flip_rem = dvd_neg;
      end else begin : g_unsigned
         logic unused_mode;
         assign unused_mode = is_signed;
         assign dvd_mag  = dividend;
         assign dvs_mag  = divisor;
         assign flip_quo = 1'b0;
         assign flip_rem = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/rdiv_iter_core.sv
module rdiv_iter_core
   import rdiv_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] dvd_mag,
   input  logic [WIDTH-1:0] dvs_mag,
   output logic             finish,
   output logic             busy,
   output logic [WIDTH-1:0] quo_mag,
   output logic [WIDTH-1:0] rem_mag
);
   localparam int CNT_W = $clog2(WIDTH + 1);
   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

   rdiv_phase_t        phase;
   logic [CNT_W-1:0]   step;
   logic [2*WIDTH-1:0] work;
   logic               ext;
   logic [WIDTH-1:0]   dvs_q;

   logic [WIDTH:0]     trial;
   logic               trial_neg;
   logic [WIDTH-1:0]   hi_next;

   // trial subtraction on the upper half plus the bit shifted out above it
   assign trial     = {ext, work[2*WIDTH-1:WIDTH]} - {1'b0, dvs_q};
   assign trial_neg = trial[WIDTH];
   assign hi_next   = trial_neg ? work[2*WIDTH-1:WIDTH] : trial[WIDTH-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         step  <= '0;
         work  <= '0;
         ext   <= 1'b0;
         dvs_q <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: if (load) begin
               work  <= {{(WIDTH-1){1'b0}}, dvd_mag, 1'b0};
               ext   <= 1'b0;
               dvs_q <= dvs_mag;
               step  <= '0;
               phase <= PH_ITER;
            end
            PH_ITER: begin
               {ext, work} <= {hi_next, work[WIDTH-1:0], ~trial_neg};
               step        <= step + 1'b1;
               if (step == LAST_STEP) phase <= PH_FIX;
            end
            PH_FIX: phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign busy    = (phase != PH_IDLE);
   assign finish  = (phase == PH_FIX);
   assign quo_mag = work[WIDTH-1:0];
   // undo the surplus shift on the upper half only
   assign rem_mag = {ext, work[2*WIDTH-1:WIDTH+1]};
endmodule

// File: rtl/rdiv_result_fix.sv
module rdiv_result_fix #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             finish,
   input  logic             flip_quo,
   input  logic             flip_rem,
   input  logic             dvs_zero,
   input  logic [WIDTH-1:0] quo_mag,
   input  logic [WIDTH-1:0] rem_mag,
   output logic             done,
   output logic [WIDTH-1:0] quotient,
   output logic [WIDTH-1:0] remainder
);
   logic [WIDTH-1:0] quo_signed, rem_signed;

   assign quo_signed = dvs_zero ? '1 : (flip_quo ? (~quo_mag + 1'b1) : quo_mag);
   assign rem_signed = flip_rem ? (~rem_mag + 1'b1) : rem_mag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done      <= 1'b0;
         quotient  <= '0;
         remainder <= '0;
      end else begin
         done <= finish;
         if (finish) begin
            quotient  <= quo_signed;
            remainder <= rem_signed;
         end
      end
   end
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
   parameter int WIDTH     = 32,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             is_signed,
   input  logic [WIDTH-1:0] dividend,
   input  logic [WIDTH-1:0] divisor,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] quotient,
   output logic [WIDTH-1:0] remainder
);
   initial begin
      if (WIDTH < 2) $error("restoring_divider: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] dvd_mag, dvs_mag, quo_mag, rem_mag;
   logic flip_quo_c, flip_rem_c, dvs_zero_c;
   logic flip_quo_q, flip_rem_q, dvs_zero_q;
   logic core_busy, finish, accept;

   assign accept = start & ~core_busy;

   rdiv_operand_prep #(.WIDTH(WIDTH), .SIGNED_EN(SIGNED_EN)) u_prep (
      .is_signed (is_signed),
      .dividend  (dividend),
      .divisor   (divisor),
      .dvd_mag   (dvd_mag),
      .dvs_mag   (dvs_mag),
      .flip_quo  (flip_quo_c),
      .flip_rem  (flip_rem_c),
      .dvs_zero  (dvs_zero_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flip_quo_q <= 1'b0;
         flip_rem_q <= 1'b0;
         dvs_zero_q <= 1'b0;
      end else if (accept) begin
         flip_quo_q <= flip_quo_c;
         flip_rem_q <= flip_rem_c;
         dvs_zero_q <= dvs_zero_c;
      end
   end

   rdiv_iter_core #(.WIDTH(WIDTH)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .dvd_mag (dvd_mag),
      .dvs_mag (dvs_mag),
      .finish  (finish),
      .busy    (core_busy),
      .quo_mag (quo_mag),
      .rem_mag (rem_mag)
   );

   rdiv_result_fix #(.WIDTH(WIDTH)) u_fix (
      .clk       (clk),
      .rst_n     (rst_n),
      .finish    (finish),
      .flip_quo  (flip_quo_q),
      .flip_rem  (flip_rem_q),
      .dvs_zero  (dvs_zero_q),
      .quo_mag   (quo_mag),
      .rem_mag   (rem_mag),
      .done      (done),
      .quotient  (quotient),
      .remainder (remainder)
   );

   assign busy = core_busy;
endmodule

// File: rtl/rdiv_checker.sv
module rdiv_checker #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic [WIDTH-1:0] quotient,
   input logic [WIDTH-1:0] remainder
);
   localparam int LEN_W = $clog2(WIDTH + 3) + 1;
   localparam logic [LEN_W-1:0] RUN_CYCLES = LEN_W'(WIDTH + 1);

   logic [LEN_W-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len <= '0;
      else if (busy) run_len <= run_len + 1'b1;
      else           run_len <= '0;
   end

   assert_busy_follows_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_busy_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_len == RUN_CYCLES));

   assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   assert_results_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(quotient) && $stable(remainder)));
endmodule

bind restoring_divider rdiv_checker #(.WIDTH(WIDTH)) u_rdiv_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .quotient  (quotient),
   .remainder (remainder)
);

// File: tb/restoring_divider_bench.sv
module restoring_divider_bench;
   localparam int W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic is_signed = 1'b0;
   logic [W-1:0] dividend = '0;
   logic [W-1:0] divisor = '0;
   logic busy, done;
   logic [W-1:0] quotient, remainder;

   int checks = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   restoring_divider #(.WIDTH(W)) u_restoring_divider (
      .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
      .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
      .quotient(quotient), .remainder(remainder));

   // behavioural reference model
   int           m_left = 0;
   bit           m_done = 1'b0;
   logic [W-1:0] m_q = '0, m_r = '0, p_q = '0, p_r = '0;
   string        m_tag = "R1", p_tag = "R1";
   string        next_tag = "R4";

   function automatic void golden(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input bit s, output logic [W-1:0] q,
                                  output logic [W-1:0] r);
      longint sa, sb;
      if (b == '0) begin
         q = '1; r = a;
      end else if (s) begin
         sa = longint'($signed(a)); sb = longint'($signed(b));
         q = W'(sa / sb); r = W'(sa % sb);
      end else begin
         sa = longint'({32'd0, a}); sb = longint'({32'd0, b});
         q = W'(sa / sb); r = W'(sa % sb);
      end
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_left = 0; m_done = 1'b0; m_q = '0; m_r = '0;
      end else begin
         m_done = 1'b0;
         if (m_left == 0 && start) begin
            golden(dividend, divisor, is_signed, p_q, p_r);
            p_tag  = next_tag;
            m_left = W + 1;
         end else if (m_left > 0) begin
            m_left = m_left - 1;
            if (m_left == 0) begin
               m_done = 1'b1; m_q = p_q; m_r = p_r; m_tag = p_tag;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (busy !== (m_left > 0)) begin
            fails++;
            $display("FAIL R2 busy actual=%0b expected=%0b", busy, (m_left > 0));
         end
         checks++;
         if (done !== m_done) begin
            fails++;
            $display("FAIL R3 done actual=%0b expected=%0b", done, m_done);
         end
         checks++;
         if (quotient !== m_q || remainder !== m_r) begin
            fails++;
            $display("FAIL %s q/r actual=%h/%h expected=%h/%h",
                     m_done ? m_tag : "R9", quotient, remainder, m_q, m_r);
         end
      end
   end

   task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit s, input string tag);
      @(negedge clk);
      while (busy) @(negedge clk);
      next_tag = tag; dividend = a; divisor = b; is_signed = s; start = 1'b1;
      @(negedge clk);
      start = 1'b0; dividend = '0; divisor = '0;
      while (!done) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (busy !== 1'b0 || done !== 1'b0 || quotient !== '0 || remainder !== '0) begin
         fails++;
         $display("FAIL R1 reset actual=%b%b/%h/%h expected=00/0/0", busy, done, quotient, remainder);
      end
      rst_n = 1'b1;
      // R4 unsigned cases, including top-bit-set operands
      run_div(32'd100, 32'd7, 1'b0, "R4");
      run_div(32'hFFFF_FFFF, 32'd1, 1'b0, "R4");
      run_div(32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b0, "R4");
      run_div(32'h8000_0001, 32'h4000_0000, 1'b0, "R4");
      run_div(32'd5, 32'd9, 1'b0, "R4");
      run_div(32'hDEAD_BEEF, 32'h0001_2345, 1'b0, "R4");
      // R5 signed quotient direction
      run_div(32'd100, -32'sd7, 1'b1, "R5");
      run_div(-32'sd100, -32'sd7, 1'b1, "R5");
      run_div(-32'sd1, 32'd2, 1'b1, "R5");
      // R6 remainder follows dividend sign
      run_div(32'd7, 32'd4, 1'b1, "R6");
      run_div(-32'sd7, 32'd4, 1'b1, "R6");
      run_div(32'd7, -32'sd4, 1'b1, "R6");
      // R7 zero divisor
      run_div(32'h1234_5678, 32'd0, 1'b0, "R7");
      run_div(32'hF000_0005, 32'd0, 1'b0, "R7");
      run_div(-32'sd9, 32'd0, 1'b1, "R7");
      // R10 most negative by -1
      run_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R10");
      // R8 start while busy is ignored
      @(negedge clk);
      next_tag = "R8"; dividend = 32'd1000; divisor = 32'd33; is_signed = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      dividend = 32'd5; divisor = 32'd0; is_signed = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      // back-to-back start in the done cycle
      next_tag = "R3"; dividend = 32'd81; divisor = 32'd9; is_signed = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      repeat (5) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule